// File: doc/BRIEF.md
# Platform System-Controller Register File

This block is a small, memory-mapped control and status register file for a board-level system controller. A host reaches it over a plain 32-bit register bus: one read strobe, one write strobe, an address, a byte-count size field and write data. Most registers are read-only words assembled from parameters and strap inputs. They cover a build identifier, a wrapper identifier, a memory-controller status word, per-link status flags, a build-configuration word, a memory-configuration word and a clock-divider word that carries the reference frequency in MHz.

The only register that acts on a write is the soft-reset register. A full-word write that sets its trigger bit makes the block raise a one-cycle reset-request pulse for the chip's reset controller. Nothing is stored.

The bus has no back-pressure. An access is accepted on every clock edge where a strobe is high. A read always answers on the next cycle with a response-valid pulse. Reads and writes must not be issued in the same cycle. Straps are sampled at the same edge as the read that returns them.

Top module: `plat_sysctl_regs`

## Requirements
- R1: While reset is held and on the first cycle after it, rdata_o, rvalid_o, unmapped_o and reset_req_o are all zero.
- R2: A 4-byte read returns fixed words: BUILD_ID at offset 0x00, WRAPPER_ID at 0x08, 0x0000_0005 at 0x14 (memory locked bit 0 and calibrated bit 2), and 0x0000_000E at 0x34 (link-enable bits 1 to 3 set, coherence-unit bit 0 clear).
- R3: A 4-byte read of 0x30 returns a clock-divider word with the following fields:
  - clock-0 divide, value 1, in bits 7:0;
  - the ref_mhz_i strap in bits 15:8;
  - multiplier, value 1, in bits 23:16;
  - clock-1 divide, value 1, in bits 31:24.
- R4: A 4-byte read of 0x38 returns mem_gib_i in bits 3:0 and all ones in bits 15:4. Bits 31:16 are zero.
- R5: A 4-byte read of 0x18 returns link_up_i[i] in bit 8*i and zero elsewhere. The decoded offsets 0x0c, 0x10, 0x1c, 0x3c, 0x40 and 0x44 read as zero and do not raise unmapped_o.
- R6: Only size_i == 4 is honoured. A read of any other size still gives rvalid_o, but rdata_o is zero. A write of any other size has no effect, even to 0x10.
- R7: Decoding uses only addr_i[15:0]. Bits 31:16 of the address do not change any result.
- R8: A 4-byte write to 0x10 with wdata_i[4] set drives reset_req_o high on the cycle after the write, for exactly one cycle. A write to 0x10 with bit 4 clear raises no request.
- R9: Writes to the read-only offsets are ignored. A later read returns the same value, and neither reset_req_o nor unmapped_o rises.
- R10: A read or write, of any size, whose offset is not one of the decoded offsets pulses unmapped_o for one cycle on the next cycle. Such a read returns zero.
- R11: rvalid_o is high exactly on the cycle after each read strobe, and rdata_o is zero whenever rvalid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rd_i | input | 1 | Read strobe, one access per cycle |
| wr_i | input | 1 | Write strobe, one access per cycle |
| addr_i | input | 32 | Byte address; only bits 15:0 decode |
| size_i | input | 3 | Access size in bytes; only 4 is honoured |
| wdata_i | input | 32 | Write data |
| ref_mhz_i | input | 8 | Strap: reference frequency in MHz |
| mem_gib_i | input | 4 | Strap: memory size in GiB |
| link_up_i | input | NUM_LINKS | Strap: per-link up flags |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response, one cycle after rd_i |
| unmapped_o | output | 1 | One-cycle pulse for an undecoded access |
| reset_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- the read-response timing, and zero read data when rvalid_o is low;
- zero data for narrow reads;
- that a reset request occurs if and only if a qualifying soft-reset write came one cycle earlier;
- that every unmapped pulse traces back to an access;
- the exact memory-status and clock-divider words.

Only the bench scenarios can show the rest. That covers the full value of every register under changing straps, the aliasing of upper address bits, and that writes to read-only registers leave the read-back value unchanged. It also covers that the single-cycle pulses fall back to zero on the following idle cycle.

// File: rtl/plat_sysctl_pkg.sv
package plat_sysctl_pkg;
  localparam int OFFS_W     = 16;
  localparam int DATA_W     = 32;
  localparam int FIELD_W    = 8;
  localparam int MHZ_W      = 8;
  localparam int GIB_W      = 4;
  localparam int SPEED_W    = 12;
  localparam int LINK_STEP  = 8;
  localparam int SIZE_W     = 3;
  localparam int SOFTRST_BIT = 4;

  localparam logic [SIZE_W-1:0] SIZE_WORD = 3'd4;

  localparam logic [OFFS_W-1:0] OFF_BUILD    = 16'h0000;
  localparam logic [OFFS_W-1:0] OFF_WRAP     = 16'h0008;
  localparam logic [OFFS_W-1:0] OFF_CLKSTAT  = 16'h000c;
  localparam logic [OFFS_W-1:0] OFF_SOFTRST  = 16'h0010;
  localparam logic [OFFS_W-1:0] OFF_MEMSTAT  = 16'h0014;
  localparam logic [OFFS_W-1:0] OFF_LINKSTAT = 16'h0018;
  localparam logic [OFFS_W-1:0] OFF_FLASH    = 16'h001c;
  localparam logic [OFFS_W-1:0] OFF_CLKDIV   = 16'h0030;
  localparam logic [OFFS_W-1:0] OFF_BUILDCFG = 16'h0034;
  localparam logic [OFFS_W-1:0] OFF_MEMCFG   = 16'h0038;
  localparam logic [OFFS_W-1:0] OFF_FABRIC0  = 16'h003c;
  localparam int                FABRIC_STEP  = 4;

  localparam logic [DATA_W-1:0] MEMSTAT_WORD = 32'h0000_0005;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_BUILD,
    SEL_WRAP,
    SEL_CLKSTAT,
    SEL_SOFTRST,
    SEL_MEMSTAT,
    SEL_LINKSTAT,
    SEL_FLASH,
    SEL_CLKDIV,
    SEL_BUILDCFG,
    SEL_MEMCFG,
    SEL_FABRIC0,
    SEL_FABRIC1,
    SEL_FABRIC2
  } reg_sel_e;
endpackage

// File: rtl/plat_sysctl_decode.sv
module plat_sysctl_decode
  import plat_sysctl_pkg::*;
#(
  parameter int NUM_LINKS = 3
) (
  input  logic [OFFS_W-1:0] offs_i,
  output reg_sel_e          sel_o,
  output logic              hit_o
);
  localparam int SEL_W = $bits(reg_sel_e);

  always_comb begin
    sel_o = SEL_NONE;
    case (offs_i)
      OFF_BUILD:    sel_o = SEL_BUILD;
      OFF_WRAP:     sel_o = SEL_WRAP;
      OFF_CLKSTAT:  sel_o = SEL_CLKSTAT;
      OFF_SOFTRST:  sel_o = SEL_SOFTRST;
      OFF_MEMSTAT:  sel_o = SEL_MEMSTAT;
      OFF_LINKSTAT: sel_o = SEL_LINKSTAT;
      OFF_FLASH:    sel_o = SEL_FLASH;
      OFF_CLKDIV:   sel_o = SEL_CLKDIV;
      OFF_BUILDCFG: sel_o = SEL_BUILDCFG;
      OFF_MEMCFG:   sel_o = SEL_MEMCFG;
      default:      sel_o = SEL_NONE;
    endcase
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (offs_i == OFF_FABRIC0 + OFFS_W'(FABRIC_STEP * i))
        sel_o = reg_sel_e'(SEL_W'(int'(SEL_FABRIC0) + i));
    end
  end

  assign hit_o = (sel_o != SEL_NONE);
endmodule

// File: rtl/plat_sysctl_readmux.sv
module plat_sysctl_readmux
  import plat_sysctl_pkg::*;
#(
  parameter int                NUM_LINKS  = 3,
  parameter logic [DATA_W-1:0] BUILD_ID   = 32'h2016_0A5C,
  parameter logic [DATA_W-1:0] WRAPPER_ID = 32'h0000_0311
) (
  input  reg_sel_e             sel_i,
  input  logic [MHZ_W-1:0]     ref_mhz_i,
  input  logic [GIB_W-1:0]     mem_gib_i,
  input  logic [NUM_LINKS-1:0] link_up_i,
  output logic [DATA_W-1:0]    word_o
);
  localparam logic [FIELD_W-1:0] UNITY = FIELD_W'(1);
  localparam int CFG_PAD = DATA_W - SPEED_W - GIB_W;

  logic [DATA_W-1:0] link_word;
  logic [DATA_W-1:0] cfg_word;
  logic [DATA_W-1:0] clkdiv_word;
  logic [DATA_W-1:0] memcfg_word;

  generate
    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
      assign link_word[LINK_STEP*g] = link_up_i[g];
      assign cfg_word[g+1]          = 1'b1;
      if (LINK_STEP > 1) begin : g_lpad
        assign link_word[LINK_STEP*g+1 +: LINK_STEP-1] = '0;
      end
    end
    if (LINK_STEP * NUM_LINKS < DATA_W) begin : g_lhi
      assign link_word[DATA_W-1:LINK_STEP*NUM_LINKS] = '0;
    end
    assign cfg_word[0] = 1'b0;
    assign cfg_word[DATA_W-1:NUM_LINKS+1] = '0;
  endgenerate

  assign clkdiv_word = {UNITY, UNITY, ref_mhz_i, UNITY};
  assign memcfg_word = {{CFG_PAD{1'b0}}, {SPEED_W{1'b1}}, mem_gib_i};

  always_comb begin
    case (sel_i)
      SEL_BUILD:    word_o = BUILD_ID;
      SEL_WRAP:     word_o = WRAPPER_ID;
      SEL_MEMSTAT:  word_o = MEMSTAT_WORD;
      SEL_LINKSTAT: word_o = link_word;
      SEL_CLKDIV:   word_o = clkdiv_word;
      SEL_BUILDCFG: word_o = cfg_word;
      SEL_MEMCFG:   word_o = memcfg_word;
      default:      word_o = '0;
    endcase
  end
endmodule

// File: rtl/plat_sysctl_pulse.sv
module plat_sysctl_pulse (
  input  logic clk_i,
  input  logic rst_i,
  input  logic fire_i,
  output logic req_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) req_o <= 1'b0;
    else       req_o <= fire_i;
  end
endmodule

// File: rtl/plat_sysctl_regs.sv
module plat_sysctl_regs
  import plat_sysctl_pkg::*;
#(
  parameter int                NUM_LINKS  = 3,
  parameter logic [DATA_W-1:0] BUILD_ID   = 32'h2016_0A5C,
  parameter logic [DATA_W-1:0] WRAPPER_ID = 32'h0000_0311
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [31:0]          addr_i,
  input  logic [SIZE_W-1:0]    size_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [MHZ_W-1:0]     ref_mhz_i,
  input  logic [GIB_W-1:0]     mem_gib_i,
  input  logic [NUM_LINKS-1:0] link_up_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 rvalid_o,
  output logic                 unmapped_o,
  output logic                 reset_req_o
);
  reg_sel_e          sel;
  logic              hit;
  logic              word_ok;
  logic              fire;
  logic [DATA_W-1:0] mux_word;
  logic              unused_bits;

  assign unused_bits = ^{addr_i[31:OFFS_W], wdata_i};

  plat_sysctl_decode #(.NUM_LINKS(NUM_LINKS)) u_decode (
    .offs_i (addr_i[OFFS_W-1:0]),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  plat_sysctl_readmux #(
    .NUM_LINKS  (NUM_LINKS),
    .BUILD_ID   (BUILD_ID),
    .WRAPPER_ID (WRAPPER_ID)
  ) u_readmux (
    .sel_i     (sel),
    .ref_mhz_i (ref_mhz_i),
    .mem_gib_i (mem_gib_i),
    .link_up_i (link_up_i),
    .word_o    (mux_word)
  );

  assign word_ok = (size_i == SIZE_WORD);
  assign fire    = wr_i && word_ok && (sel == SEL_SOFTRST) && wdata_i[SOFTRST_BIT];

  plat_sysctl_pulse u_pulse (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .fire_i (fire),
    .req_o  (reset_req_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_o    <= '0;
      rvalid_o   <= 1'b0;
      unmapped_o <= 1'b0;
    end else begin
      rvalid_o   <= rd_i;
      rdata_o    <= (rd_i && word_ok) ? mux_word : '0;
      unmapped_o <= (rd_i || wr_i) && !hit;
    end
  end

  assert_rvalid_follows_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_i |=> rvalid_o);
  assert_rvalid_origin_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    rvalid_o |-> $past(rd_i));
  assert_idle_rdata_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    !rvalid_o |-> (rdata_o == '0));
  assert_narrow_read_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (rvalid_o && ($past(size_i) != 3'd4)) |-> (rdata_o == '0));
  assert_reset_origin_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    reset_req_o |-> $past(wr_i && size_i == 3'd4 && addr_i[15:0] == 16'h0010 && wdata_i[4]));
  assert_reset_fires_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && size_i == 3'd4 && addr_i[15:0] == 16'h0010 && wdata_i[4]) |=> reset_req_o);
  assert_unmapped_origin_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    unmapped_o |-> $past(rd_i || wr_i));
  assert_memstat_word_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (rvalid_o && $past(addr_i[15:0] == 16'h0014 && size_i == 3'd4)) |-> (rdata_o == 32'h5));
  assert_clkdiv_word_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (rvalid_o && $past(addr_i[15:0] == 16'h0030 && size_i == 3'd4))
      |-> (rdata_o == {8'd1, 8'd1, $past(ref_mhz_i), 8'd1}));
endmodule

// File: tb/tb_plat_sysctl_regs.sv
module tb_plat_sysctl_regs;
  localparam int NL = 3;
  localparam logic [31:0] BID = 32'h2016_0A5C;
  localparam logic [31:0] WID = 32'h0000_0311;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_i = 1'b0, wr_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [2:0] size_i = 3'd4;
  logic [7:0] ref_mhz_i = 8'd50;
  logic [3:0] mem_gib_i = 4'd2;
  logic [NL-1:0] link_up_i = 3'b101;
  logic [31:0] rdata_o;
  logic rvalid_o, unmapped_o, reset_req_o;

  int total = 0, failed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  plat_sysctl_regs #(.NUM_LINKS(NL), .BUILD_ID(BID), .WRAPPER_ID(WID)) dut (
    .clk_i(clk), .rst_i(rst), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .ref_mhz_i(ref_mhz_i),
    .mem_gib_i(mem_gib_i), .link_up_i(link_up_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .unmapped_o(unmapped_o), .reset_req_o(reset_req_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_mapped(input logic [31:0] a);
    case (a[15:0])
      16'h00, 16'h08, 16'h0c, 16'h10, 16'h14, 16'h18, 16'h1c,
      16'h30, 16'h34, 16'h38, 16'h3c, 16'h40, 16'h44: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] model_rd(input logic [31:0] a, input logic [2:0] sz,
                                           input logic [7:0] mhz, input logic [3:0] gib,
                                           input logic [NL-1:0] lk);
    if (sz != 3'd4) return 32'h0;
    case (a[15:0])
      16'h00: return BID;
      16'h08: return WID;
      16'h14: return 32'h5;
      16'h18: return {7'h0, lk[2], 7'h0, lk[1], 7'h0, lk[0]};
      16'h30: return {8'd1, 8'd1, mhz, 8'd1};
      16'h34: return 32'hE;
      16'h38: return {16'h0, 12'hFFF, gib};
      default: return 32'h0;
    endcase
  endfunction

  task automatic xfer(input string req, input logic r, input logic w,
                      input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] exp_d;
    logic exp_um, exp_rq;
    @(negedge clk);
    rd_i = r; wr_i = w; addr_i = a; size_i = sz; wdata_i = d;
    exp_d  = r ? model_rd(a, sz, ref_mhz_i, mem_gib_i, link_up_i) : 32'h0;
    exp_um = (r || w) && !is_mapped(a);
    exp_rq = w && sz == 3'd4 && a[15:0] == 16'h0010 && d[4];
    @(posedge clk); #2;
    chk({req, " rvalid"}, {31'h0, rvalid_o}, {31'h0, r});
    chk({req, " rdata"}, rdata_o, exp_d);
    chk({req, " unmapped"}, {31'h0, unmapped_o}, {31'h0, exp_um});
    chk({req, " reset_req"}, {31'h0, reset_req_o}, {31'h0, exp_rq});
    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0;
    @(posedge clk); #2;
    chk({req, " idle pulses"}, {29'h0, rvalid_o, unmapped_o, reset_req_o}, 32'h0);
    chk({req, " idle rdata R11"}, rdata_o, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] offs [13] = '{32'h00, 32'h08, 32'h0c, 32'h10, 32'h14, 32'h18, 32'h1c,
                               32'h30, 32'h34, 32'h38, 32'h3c, 32'h40, 32'h44};
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset outputs", {28'h0, rvalid_o, unmapped_o, reset_req_o, 1'b0}, 32'h0);
    chk("R1 reset rdata", rdata_o, 32'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk("R1 first cycle", {29'h0, rvalid_o, unmapped_o, reset_req_o}, 32'h0);

    xfer("R2 build id", 1, 0, 32'h00, 3'd4, 0);
    xfer("R2 wrapper id", 1, 0, 32'h08, 3'd4, 0);
    xfer("R2 mem status", 1, 0, 32'h14, 3'd4, 0);
    xfer("R2 build cfg", 1, 0, 32'h34, 3'd4, 0);
    xfer("R3 clock divider", 1, 0, 32'h30, 3'd4, 0);
    ref_mhz_i = 8'hC8;
    xfer("R3 clock divider 200MHz", 1, 0, 32'h30, 3'd4, 0);
    xfer("R4 mem cfg", 1, 0, 32'h38, 3'd4, 0);
    mem_gib_i = 4'hF;
    xfer("R4 mem cfg max", 1, 0, 32'h38, 3'd4, 0);
    xfer("R5 link status", 1, 0, 32'h18, 3'd4, 0);
    link_up_i = 3'b010;
    xfer("R5 link status b", 1, 0, 32'h18, 3'd4, 0);
    xfer("R5 zero clkstat", 1, 0, 32'h0c, 3'd4, 0);
    xfer("R5 zero softrst", 1, 0, 32'h10, 3'd4, 0);
    xfer("R5 zero fabric2", 1, 0, 32'h44, 3'd4, 0);
    xfer("R6 narrow read", 1, 0, 32'h00, 3'd2, 0);
    xfer("R6 wide read", 1, 0, 32'h34, 3'd0, 0);
    xfer("R6 narrow reset write", 0, 1, 32'h10, 3'd1, 32'hFFFF_FFFF);
    xfer("R7 alias clkdiv", 1, 0, 32'hABCD_0030, 3'd4, 0);
    xfer("R7 alias reset", 0, 1, 32'h5A5A_0010, 3'd4, 32'h10);
    xfer("R8 reset write", 0, 1, 32'h10, 3'd4, 32'h10);
    xfer("R8 bit4 clear", 0, 1, 32'h10, 3'd4, 32'hFFFF_FFEF);
    xfer("R9 write build", 0, 1, 32'h00, 3'd4, 32'hFFFF_FFFF);
    xfer("R9 readback build", 1, 0, 32'h00, 3'd4, 0);
    xfer("R9 write memstat", 0, 1, 32'h14, 3'd4, 32'h0);
    xfer("R9 readback memstat", 1, 0, 32'h14, 3'd4, 0);
    xfer("R9 write linkstat", 0, 1, 32'h18, 3'd4, 32'hFFFF_FFFF);
    xfer("R9 readback linkstat", 1, 0, 32'h18, 3'd4, 0);
    xfer("R10 unmapped read", 1, 0, 32'h20, 3'd4, 0);
    xfer("R10 unmapped write", 0, 1, 32'h04, 3'd4, 32'h10);
    xfer("R10 misaligned read", 1, 0, 32'h11, 3'd4, 0);
    xfer("R10 narrow unmapped", 0, 1, 32'h48, 3'd2, 0);

    for (int n = 0; n < 400; n++) begin
      logic r, w;
      logic [31:0] a, d;
      logic [2:0] sz;
      r = $urandom_range(0, 1) == 1;
      w = !r;
      if ($urandom_range(0, 3) != 0) a = offs[$urandom_range(0, 12)] | ($urandom() & 32'hFFFF_0000);
      else a = $urandom();
      case ($urandom_range(0, 4))
        0: sz = 3'd1;
        1: sz = 3'd2;
        2: sz = 3'd8;
        default: sz = 3'd4;
      endcase
      d = $urandom();
      ref_mhz_i = 8'($urandom());
      mem_gib_i = 4'($urandom());
      link_up_i = NL'($urandom());
      xfer("R11 random", r, w, a, sz, d);
    end
    summary();
  end
endmodule